// File: doc/BRIEF.md
# Two-Pass Subranging Conversion Sequencer

This block controls a feed-forward conversion that gives a 12-bit result from 6-bit flash converters. When a start is accepted, it asks the external sample-and-hold to freeze the input. It then opens a coarse conversion window and latches the 6-bit coarse code. The coarse code goes to a DAC whose output is subtracted from the held input and amplified by 32. After a settling wait, the block opens a fine conversion window and reads a 7-bit fine word. At the end it adds the two codes into one 12-bit word.

The fine word comes from two 6-bit converters stacked on one ladder. The overflow of the lower converter decides which converter supplies the six low bits, and that overflow also becomes the seventh bit. The coarse converter is biased upward by one coarse step, so the block subtracts that step when it combines the codes. The resulting one-bit overlap corrects a coarse reading that is one step high or one step low.

Each window length is a cycle-count parameter. The defaults give 505 ns from accepting a start to the result, with a 200 MHz clock.

The start interface is a valid/ready pair, and a start is taken on any edge where both are high. Ready is high only while the block is idle, so a request made while busy is held off and does nothing. The result output has no back-pressure. It is announced by a single-cycle done pulse and then stays on the result port.

Top module: `subr_adc_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it is released, start_ready is 1, and sh_hold, coarse_conv, dac_valid, fine_conv and done are all 0. The result is 0.
- R2: A start is accepted on an edge where start_valid and start_ready are both 1. start_ready is 0 from the accepting edge until the cycle after done, so a start_valid raised during a conversion has no effect on the timing or on the result.
- R3: After the accepting edge, sh_hold is 1 for HOLD_CYC+COARSE_CYC+SETTLE_CYC+FINE_CYC cycles. Within that span, coarse_conv is 1 for COARSE_CYC cycles starting HOLD_CYC cycles in. dac_valid follows at once for SETTLE_CYC+FINE_CYC cycles. fine_conv is 1 for the last FINE_CYC of those cycles.
- R4: The coarse code is sampled in the last cycle of the coarse window, and values at other times are ignored. While dac_valid is 1, dac_code equals that sample and does not change.
- R5: The fine inputs are sampled in the last cycle of the fine window, and the fine value is chosen as follows. If lo_ovf is 0, the fine value is lo_code and hi_code is ignored. If lo_ovf is 1 and hi_ovf is 0, it is 64 + hi_code. If both overflows are 1, it is 128.
- R6: The result is coarse*64 + fine - 64, where coarse is the sampled coarse code and fine is the value from R5.
- R7: If the sum in R6 is above 4095, the result is 4095.
- R8: If the sum in R6 is below 0, the result is 0.
- R9: done is 1 for exactly one cycle. It rises HOLD_CYC+COARSE_CYC+SETTLE_CYC+FINE_CYC+1 cycles after the accepting edge, which is 101 cycles (505 ns) with the defaults.
- R10: The result changes only in the cycle in which done is 1. It holds its value through the next conversion until that conversion's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_valid | input | 1 | Request to start a conversion |
| start_ready | output | 1 | High while idle and able to accept a start |
| sh_hold | output | 1 | Keeps the sample-and-hold in hold |
| coarse_conv | output | 1 | Coarse conversion window |
| coarse_code | input | 6 | Code from the coarse converter |
| dac_valid | output | 1 | DAC code is valid and the residue is settling or being converted |
| dac_code | output | 6 | Code driven to the residue DAC |
| fine_conv | output | 1 | Fine conversion window |
| lo_code | input | 6 | Code from the lower fine converter |
| lo_ovf | input | 1 | Overflow of the lower fine converter |
| hi_code | input | 6 | Code from the upper fine converter |
| hi_ovf | input | 1 | Overflow of the upper fine converter |
| done | output | 1 | One-cycle pulse when the result is new |
| result | output | 12 | Combined 12-bit result |

## Verification
The hardest case to reach is proving that a code is taken only in the last cycle of its window. A converter that holds one value steady would hide a capture made too early or too late. The bench model drives the true code only while the matching window strobe is high, and drives the bitwise complement at all other times, so a sample taken in the wrong cycle gives a different result. The result extremes also need codes that a well-behaved analog path rarely produces: both fine overflows high with a full-scale coarse code, and a zero coarse code with no fine overflow. The bench drives these directly.

// File: rtl/subr_pkg.sv
package subr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_COARSE,
    ST_SETTLE,
    ST_FINE,
    ST_COMBINE,
    ST_DONE
  } phase_t;
endpackage

// File: rtl/subr_seq.sv
module subr_seq
  import subr_pkg::*;
#(
  parameter int HOLD_CYC   = 12,
  parameter int COARSE_CYC = 24,
  parameter int SETTLE_CYC = 40,
  parameter int FINE_CYC   = 24
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_valid,
  output logic   start_ready,
  output phase_t phase,
  output logic   last
);
  localparam int MAX_AB = (HOLD_CYC > COARSE_CYC) ? HOLD_CYC : COARSE_CYC;
  localparam int MAX_CD = (SETTLE_CYC > FINE_CYC) ? SETTLE_CYC : FINE_CYC;
  localparam int MAX_N  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_N + 1);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;

  // Reload value for a timed phase: its length minus one.
  function automatic logic [CNT_W-1:0] span_of(input phase_t p);
    case (p)
      ST_HOLD:   span_of = CNT_W'(HOLD_CYC - 1);
      ST_COARSE: span_of = CNT_W'(COARSE_CYC - 1);
      ST_SETTLE: span_of = CNT_W'(SETTLE_CYC - 1);
      ST_FINE:   span_of = CNT_W'(FINE_CYC - 1);
      default:   span_of = '0;
    endcase
  endfunction

  function automatic phase_t after(input phase_t p);
    case (p)
      ST_HOLD:    after = ST_COARSE;
      ST_COARSE:  after = ST_SETTLE;
      ST_SETTLE:  after = ST_FINE;
      ST_FINE:    after = ST_COMBINE;
      ST_COMBINE: after = ST_DONE;
      default:    after = ST_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        ST_IDLE: begin
          if (start_valid) begin
            ph  <= ST_HOLD;
            cnt <= span_of(ST_HOLD);
          end
        end
        ST_HOLD, ST_COARSE, ST_SETTLE, ST_FINE: begin
          if (cnt == '0) begin
            ph  <= after(ph);
            cnt <= span_of(after(ph));
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          ph  <= after(ph);
          cnt <= '0;
        end
      endcase
    end
  end

  assign phase       = ph;
  assign last        = (cnt == '0);
  assign start_ready = (ph == ST_IDLE);
endmodule

// File: rtl/subr_fine_sel.sv
module subr_fine_sel #(
  parameter int FINE_W = 6
) (
  input  logic [FINE_W-1:0] lo_code,
  input  logic              lo_ovf,
  input  logic [FINE_W-1:0] hi_code,
  input  logic              hi_ovf,
  output logic [FINE_W+1:0] fine_val
);
  // Lower overflow becomes the extra fine bit and steers the low bits.
  always_comb begin
    if (!lo_ovf)
      fine_val = {2'b00, lo_code};
    else if (hi_ovf)
      fine_val = {2'b10, {FINE_W{1'b0}}};
    else
      fine_val = {2'b01, hi_code};
  end
endmodule

// File: rtl/subr_combine.sv
module subr_combine #(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 6
) (
  input  logic [COARSE_W-1:0]        coarse,
  input  logic [FINE_W+1:0]          fine_val,
  output logic [COARSE_W+FINE_W-1:0] sum_out
);
  localparam int OUT_W  = COARSE_W + FINE_W;
  localparam int SUM_W  = OUT_W + 2;
  localparam int OFFSET = 1 << FINE_W;
  localparam int TOPV   = (1 << OUT_W) - 1;

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed(SUM_W'({coarse, {FINE_W{1'b0}}}))
        + $signed(SUM_W'(fine_val))
        - $signed(SUM_W'(OFFSET));
    if (sum < 0)
      sum_out = '0;
    else if (sum > $signed(SUM_W'(TOPV)))
      sum_out = OUT_W'(TOPV);
    else
      sum_out = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/subr_adc_ctrl.sv
module subr_adc_ctrl
  import subr_pkg::*;
#(
  parameter int COARSE_W   = 6,
  parameter int FINE_W     = 6,
  parameter int HOLD_CYC   = 12,
  parameter int COARSE_CYC = 24,
  parameter int SETTLE_CYC = 40,
  parameter int FINE_CYC   = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_valid,
  output logic                       start_ready,
  output logic                       sh_hold,
  output logic                       coarse_conv,
  input  logic [COARSE_W-1:0]        coarse_code,
  output logic                       dac_valid,
  output logic [COARSE_W-1:0]        dac_code,
  output logic                       fine_conv,
  input  logic [FINE_W-1:0]          lo_code,
  input  logic                       lo_ovf,
  input  logic [FINE_W-1:0]          hi_code,
  input  logic                       hi_ovf,
  output logic                       done,
  output logic [COARSE_W+FINE_W-1:0] result
);
  localparam int OUT_W = COARSE_W + FINE_W;

  phase_t              phase;
  logic                last;
  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W+1:0]   fine_now;
  logic [FINE_W+1:0]   fine_q;
  logic [OUT_W-1:0]    sum_w;
  logic [OUT_W-1:0]    result_q;

  subr_seq #(
    .HOLD_CYC  (HOLD_CYC),
    .COARSE_CYC(COARSE_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .FINE_CYC  (FINE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(start_valid),
    .start_ready(start_ready),
    .phase      (phase),
    .last       (last)
  );

  subr_fine_sel #(.FINE_W(FINE_W)) u_sel (
    .lo_code (lo_code),
    .lo_ovf  (lo_ovf),
    .hi_code (hi_code),
    .hi_ovf  (hi_ovf),
    .fine_val(fine_now)
  );

  subr_combine #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_comb (
    .coarse  (coarse_q),
    .fine_val(fine_q),
    .sum_out (sum_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q <= '0;
      fine_q   <= '0;
      result_q <= '0;
    end else begin
      if (phase == ST_COARSE && last) coarse_q <= coarse_code;
      if (phase == ST_FINE && last)   fine_q   <= fine_now;
      if (phase == ST_COMBINE)        result_q <= sum_w;
    end
  end

  assign sh_hold     = (phase == ST_HOLD) || (phase == ST_COARSE) ||
                       (phase == ST_SETTLE) || (phase == ST_FINE);
  assign coarse_conv = (phase == ST_COARSE);
  assign dac_valid   = (phase == ST_SETTLE) || (phase == ST_FINE);
  assign fine_conv   = (phase == ST_FINE);
  assign dac_code    = coarse_q;
  assign done        = (phase == ST_DONE);
  assign result      = result_q;
endmodule

// File: rtl/subr_adc_ctrl_chk.sv
module subr_adc_ctrl_chk #(
  parameter int COARSE_W = 6,
  parameter int OUT_W    = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_ready,
  input logic                sh_hold,
  input logic                coarse_conv,
  input logic                fine_conv,
  input logic                dac_valid,
  input logic [COARSE_W-1:0] dac_code,
  input logic                done,
  input logic [OUT_W-1:0]    result
);
  // R2: no start can be taken while the input is being held
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sh_hold |-> !start_ready);

  // R3: conversion windows lie inside the hold span and never overlap
  a_r3_windows_held: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_conv || fine_conv || dac_valid) |-> sh_hold);
  a_r3_windows_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({coarse_conv, dac_valid}));

  // R4: the DAC code does not move while it is marked valid
  a_r4_dac_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && $past(dac_valid)) |-> $stable(dac_code));

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: the result moves only with done
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind subr_adc_ctrl subr_adc_ctrl_chk #(.COARSE_W(COARSE_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_ready(start_ready),
  .sh_hold    (sh_hold),
  .coarse_conv(coarse_conv),
  .fine_conv  (fine_conv),
  .dac_valid  (dac_valid),
  .dac_code   (dac_code),
  .done       (done),
  .result     (result)
);

// File: tb/subr_adc_ctrl_test.sv
`timescale 1ns/1ps
module subr_adc_ctrl_test;
  localparam int H = 12, C = 24, S = 40, F = 24;
  localparam int LAT = H + C + S + F + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready, sh_hold, coarse_conv, dac_valid, fine_conv, done;
  logic [5:0] coarse_code, dac_code, lo_code, hi_code;
  logic lo_ovf, hi_ovf;
  logic [11:0] result;

  // converter model values; true only inside their windows
  logic [5:0] m_c = 6'd0, m_lo = 6'd0, m_hi = 6'd0;
  logic m_lo_o = 1'b0, m_hi_o = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign coarse_code = coarse_conv ? m_c : ~m_c;
  assign lo_code     = fine_conv ? m_lo : ~m_lo;
  assign lo_ovf      = fine_conv ? m_lo_o : ~m_lo_o;
  assign hi_code     = fine_conv ? m_hi : ~m_hi;
  assign hi_ovf      = fine_conv ? m_hi_o : ~m_hi_o;

  subr_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .sh_hold(sh_hold), .coarse_conv(coarse_conv), .coarse_code(coarse_code),
    .dac_valid(dac_valid), .dac_code(dac_code), .fine_conv(fine_conv),
    .lo_code(lo_code), .lo_ovf(lo_ovf), .hi_code(hi_code), .hi_ovf(hi_ovf),
    .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(start_ready == 1'b1, "R1", "ready in reset", start_ready, 1);
    chk({sh_hold, coarse_conv, dac_valid, fine_conv, done} == 5'b0, "R1", "strobes in reset",
        {sh_hold, coarse_conv, dac_valid, fine_conv, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(result == 12'd0, "R1", "result after reset", result, 0);
    chk(start_ready == 1'b1 && done == 1'b0, "R1", "idle after reset", start_ready, 1);
  endtask

  // One full conversion with given converter codes and expected result.
  task automatic run_conv(input int c, input int lo, input int lo_o, input int hi,
                          input int hi_o, input int exp, input bit poke, input string tag);
    int n = 0;
    int n_hold = 0, n_coarse = 0, n_dac = 0, n_fine = 0;
    int first_coarse = -1, first_dac = -1, first_fine = -1;
    int dac_bad = 0, res_moved = 0, ready_busy = 0;
    logic [11:0] prev;
    @(negedge clk);
    m_c = 6'(c); m_lo = 6'(lo); m_lo_o = 1'(lo_o); m_hi = 6'(hi); m_hi_o = 1'(hi_o);
    prev = result;
    chk(start_ready == 1'b1, "R2", {tag, " ready before start"}, start_ready, 1);
    start_valid = 1'b1;
    @(posedge clk);
    #1;
    start_valid = 1'b0;
    while (!done && n < 400) begin
      if (sh_hold) n_hold++;
      if (start_ready) ready_busy++;
      if (coarse_conv) begin n_coarse++; if (first_coarse < 0) first_coarse = n; end
      if (dac_valid) begin
        n_dac++;
        if (first_dac < 0) first_dac = n;
        if (dac_code != m_c) dac_bad++;
      end
      if (fine_conv) begin n_fine++; if (first_fine < 0) first_fine = n; end
      if (result != prev) res_moved++;
      if (poke && n == 30) start_valid = 1'b1;
      if (poke && n == 31) start_valid = 1'b0;
      @(posedge clk);
      #1;
      n++;
    end
    chk(n == LAT, "R9", {tag, " latency cycles"}, n, LAT);
    chk(n * 5 >= 500 && n * 5 <= 900, "R9", {tag, " latency ns in budget"}, n * 5, 505);
    chk(n_hold == H + C + S + F, "R3", {tag, " hold cycles"}, n_hold, H + C + S + F);
    chk(n_coarse == C && first_coarse == H, "R3", {tag, " coarse window start"}, first_coarse, H);
    chk(n_dac == S + F && first_dac == H + C, "R3", {tag, " dac window start"}, first_dac, H + C);
    chk(n_fine == F && first_fine == H + C + S, "R3", {tag, " fine window start"}, first_fine, H + C + S);
    chk(dac_bad == 0, "R4", {tag, " dac code follows coarse sample"}, dac_bad, 0);
    chk(ready_busy == 0, "R2", {tag, " ready low while busy"}, ready_busy, 0);
    chk(res_moved == 0, "R10", {tag, " result held during conversion"}, res_moved, 0);
    chk(result == 12'(exp), "R6", {tag, " result"}, result, exp);
    @(posedge clk);
    #1;
    chk(done == 1'b0, "R9", {tag, " done single cycle"}, done, 0);
    chk(start_ready == 1'b1, "R2", {tag, " ready after done"}, start_ready, 1);
    repeat (3) @(posedge clk);
    #1;
    chk(result == 12'(exp), "R10", {tag, " result stays"}, result, exp);
    chk(sh_hold == 1'b0, "R2", {tag, " no extra conversion"}, sh_hold, 0);
  endtask

  initial begin
    reset_test();
    // R6 / R5: low converter path, upper code ignored
    run_conv(33, 17, 0, 55, 1, 2065, 1'b0, "R5 lower path");
    // R5: lower overflow steers to upper converter (overlap correction)
    run_conv(5, 40, 1, 3, 0, 323, 1'b0, "R5 upper path");
    // R7: both overflows at full coarse scale saturate
    run_conv(63, 12, 1, 9, 1, 4095, 1'b0, "R7 saturate");
    // R6: exact top without saturation
    run_conv(63, 0, 1, 63, 0, 4095, 1'b0, "R6 top exact");
    // R8: negative sum clamps
    run_conv(0, 10, 0, 0, 0, 0, 1'b0, "R8 clamp");
    // R8: zero coarse plus upper path yields small positive
    run_conv(0, 0, 1, 5, 0, 5, 1'b0, "R8 upper small");
    // R6: exact zero boundary
    run_conv(1, 0, 0, 7, 0, 0, 1'b0, "R6 zero exact");
    // R2: start during busy has no effect
    run_conv(40, 63, 0, 1, 0, 2559, 1'b1, "R2 busy start");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule